// File: doc/BRIEF.md
# Bit-Serial Decision Feedback Equalizer for Binary Symbols

This block recovers binary antipodal symbols from a stream of received samples that carry intersymbol interference. Each accepted sample enters a feedforward delay line. The most recent past decisions sit in a feedback delay line. Both lines are weighted by fixed coefficients. The weighted feedback sum is subtracted from the weighted feedforward sum, and a sign slicer turns the difference into a symbol decision. That decision is written back as the newest feedback entry, so it can cancel trailing interference on the symbols that follow.

Neither filter has a multiplier. Both are bit-serial distributed arithmetic engines that run in lockstep under one sequencer. In every cycle, each engine takes one bit position from all its stored words. Each set bit enables its tap's coefficient, and the enabled coefficients are added into a partial sum. A shift-accumulator then builds the full inner product, starting from the sign bit. A sample pass takes W cycles. The decision is registered on the last of them, and the block then takes the next sample.

Top module: `bpsk_dfe`

## Requirements
- R1: Reset clears both delay lines to zero and leaves `dec_valid` low and `in_ready` high. With zero history, a zero sample therefore gives a slicer input of zero.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for the next W clock cycles.
- R3: `dec_valid` is high for exactly one cycle. That cycle is the one after the W-th rising edge that follows the accepting edge. `in_ready` is high in that same cycle.
- R4: A sample presented while `in_ready` is low is ignored. It changes neither the current decision nor any later one.
- R5: The slicer input is S = sum(d[i]*x[k-i], i=0..NF-1) - sum(b[j]*r[k-1-j], j=0..NB-1). Here x[k] is the newest accepted sample, and r[k-1] is the decision of the previous sample.
- R6: `dec_symbol` is 1 (symbol +1) when S >= 0, and 0 (symbol -1) when S < 0.
- R7: The decision enters the feedback line as the W-bit word +(2^(W-1)-1) for symbol +1, or -(2^(W-1)-1) for symbol -1. It enters on the same edge that raises `dec_valid`.
- R8: Samples are W-bit two's complement numbers. Every value from -2^(W-1) to 2^(W-1)-1 is weighted exactly, including the sign bit.
- R9: Symbols sent through a three-tap postcursor channel x[k] = 32s[k] + 24s[k-1] + 16s[k-2] are recovered without error. The coefficients for this case are d = {16,0,0,0} and b = {3,2,0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received sample is present |
| in_sample | input | W | Received sample, two's complement |
| in_ready | output | 1 | Block can accept a sample |
| dec_valid | output | 1 | One-cycle strobe: a decision is available |
| dec_symbol | output | 1 | Decision: 1 means +1, 0 means -1 |

## Verification
The hardest state to reach is a decision that depends on earlier decisions fed back. The bench cannot load the feedback line directly. It can only fill it by driving sample sequences whose own decisions are known.

The stimulus therefore sweeps every sample value in order, which builds up a long run of mixed decisions. A reference model computes each slicer input exactly from its own history. After that, symbols are sent through an interfering channel that is strong enough to flip symbols unless the feedback path cancels the interference. Samples driven during a busy pass show that an ignored input leaves the following decisions unchanged.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dfe_state_e;
endpackage

// File: rtl/dfe_ctrl.sv
module dfe_ctrl
  import dfe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic                  accept,
  output logic                  run,
  output logic                  first,
  output logic                  last,
  output logic [$clog2(W)-1:0]  bit_idx,
  output logic                  dec_valid
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] TOP_BIT = BW'(W - 1);

  dfe_state_e    state_q, state_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic          dval_q, dval_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_RUN;
          cnt_d   = TOP_BIT;
        end
      end
      default: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
    endcase
    dval_d = (state_q == ST_RUN) && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dval_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dval_q  <= dval_d;
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_ready && in_valid;
  assign run       = (state_q == ST_RUN);
  assign first     = run && (cnt_q == TOP_BIT);
  assign last      = run && (cnt_q == '0);
  assign bit_idx   = cnt_q;
  assign dec_valid = dval_q;

  // R2: an accepted sample starts a busy pass
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R3: the strobe lasts one cycle and coincides with readiness
  p_strobe_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  p_strobe_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> in_ready);
endmodule

// File: rtl/dfe_da_filter.sv
module dfe_da_filter #(
  parameter int TAPS = 4,
  parameter int W    = 8,
  parameter int CW   = 8,
  parameter int AW   = 20,
  parameter logic [TAPS*CW-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [W-1:0]         load_word,
  input  logic                 run,
  input  logic                 first,
  input  logic [$clog2(W)-1:0] bit_idx,
  output logic signed [AW-1:0] acc_nxt,
  output logic [W-1:0]         head
);
  logic [W-1:0]          bank_q [TAPS];
  logic [W-1:0]          bank_d [TAPS];
  logic signed [CW-1:0]  pick   [TAPS];
  logic signed [AW-1:0]  psum;
  logic signed [AW-1:0]  acc_q;

  // coefficient-or-zero selector per tap, driven by the current bit plane
  for (genvar k = 0; k < TAPS; k++) begin : g_sel
    localparam logic signed [CW-1:0] CK = COEF[k*CW +: CW];
    assign pick[k] = bank_q[k][bit_idx] ? CK : '0;
  end

  always_comb begin
    psum = '0;
    for (int k = 0; k < TAPS; k++)
      psum = psum + {{(AW-CW){pick[k][CW-1]}}, pick[k]};
  end

  // sign-bit plane first: it carries negative weight
  assign acc_nxt = first ? -psum : (acc_q <<< 1) + psum;

  always_comb begin
    for (int k = 0; k < TAPS; k++) bank_d[k] = bank_q[k];
    if (load_en) begin
      bank_d[0] = load_word;
      for (int k = 1; k < TAPS; k++) bank_d[k] = bank_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) bank_q[k] <= '0;
      acc_q <= '0;
    end else begin
      for (int k = 0; k < TAPS; k++) bank_q[k] <= bank_d[k];
      if (run) acc_q <= acc_nxt;
    end
  end

  assign head = bank_q[0];

  // R4: without a load the newest entry keeps its value
  p_hold_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(bank_q[0]));
  if (TAPS > 1) begin : g_shift_chk
    // R5: a load moves the older entries one tap down
    p_shift_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> bank_q[1] == $past(bank_q[0]));
  end
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
  parameter int W  = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 decide,
  input  logic signed [AW-1:0] ff_val,
  input  logic signed [AW-1:0] fb_val,
  output logic [W-1:0]         push_word,
  output logic                 dec_symbol
);
  localparam logic [W-1:0] POS_FS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_FS = {1'b1, {(W-2){1'b0}}, 1'b1};

  logic signed [AW:0] diff;
  logic               dec_d, dec_q;

  assign diff      = {ff_val[AW-1], ff_val} - {fb_val[AW-1], fb_val};
  assign dec_d     = decide ? ~diff[AW] : dec_q;
  assign push_word = (~diff[AW]) ? POS_FS : NEG_FS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_q <= 1'b0;
    else        dec_q <= dec_d;
  end

  assign dec_symbol = dec_q;

  // R6: a zero slicer input resolves to +1
  p_tie_plus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && diff == '0) |=> dec_symbol);
endmodule

// File: rtl/bpsk_dfe.sv
module bpsk_dfe #(
  parameter int W  = 8,
  parameter int CW = 8,
  parameter int NF = 4,
  parameter int NB = 3,
  parameter logic [NF*CW-1:0] FF_COEF = {8'sd0, 8'sd0, 8'sd0, 8'sd16},
  parameter logic [NB*CW-1:0] FB_COEF = {8'sd0, 8'sd2, 8'sd3}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  output logic         in_ready,
  output logic         dec_valid,
  output logic         dec_symbol
);
  localparam int NMAX = (NF > NB) ? NF : NB;
  localparam int AW   = W + CW + $clog2(NMAX) + 2;
  localparam int BW   = $clog2(W);
  localparam logic [W-1:0] POS_FS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_FS = {1'b1, {(W-2){1'b0}}, 1'b1};

  logic                 accept, run, first, last;
  logic [BW-1:0]        bit_idx;
  logic signed [AW-1:0] ff_nxt, fb_nxt;
  logic [W-1:0]         ff_head, fb_head, push_word;

  dfe_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .run(run), .first(first), .last(last),
    .bit_idx(bit_idx), .dec_valid(dec_valid)
  );

  dfe_da_filter #(.TAPS(NF), .W(W), .CW(CW), .AW(AW), .COEF(FF_COEF)) u_ff (
    .clk(clk), .rst_n(rst_n), .load_en(accept), .load_word(in_sample),
    .run(run), .first(first), .bit_idx(bit_idx),
    .acc_nxt(ff_nxt), .head(ff_head)
  );

  dfe_da_filter #(.TAPS(NB), .W(W), .CW(CW), .AW(AW), .COEF(FB_COEF)) u_fb (
    .clk(clk), .rst_n(rst_n), .load_en(last), .load_word(push_word),
    .run(run), .first(first), .bit_idx(bit_idx),
    .acc_nxt(fb_nxt), .head(fb_head)
  );

  dfe_slicer #(.W(W), .AW(AW)) u_slice (
    .clk(clk), .rst_n(rst_n), .decide(last),
    .ff_val(ff_nxt), .fb_val(fb_nxt),
    .push_word(push_word), .dec_symbol(dec_symbol)
  );

  // R7: the fed-back word matches the published decision
  p_fb_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> fb_head == (dec_symbol ? POS_FS : NEG_FS));
  // R2: an accepted sample lands in the feedforward line
  p_ff_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ff_head == $past(in_sample));
endmodule

// File: tb/test_bpsk_dfe.sv
module test_bpsk_dfe;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NF = 4;
  localparam int NB = 3;
  localparam int FS = 127;

  logic clk = 1'b0;
  logic rst_n, in_valid;
  logic [W-1:0] in_sample;
  logic in_ready, dec_valid, dec_symbol;

  int n_run = 0, n_fail = 0;
  int ffc [NF] = '{16, 0, 0, 0};
  int fbc [NB] = '{3, 2, 0};
  int xh  [NF];
  int rh  [NB];
  int last_exp;
  int last_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpsk_dfe #(
    .W(W), .CW(8), .NF(NF), .NB(NB),
    .FF_COEF({8'sd0, 8'sd0, 8'sd0, 8'sd16}),
    .FB_COEF({8'sd0, 8'sd2, 8'sd3})
  ) i_bpsk_dfe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .dec_valid(dec_valid), .dec_symbol(dec_symbol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    for (int i = 0; i < NF; i++) xh[i] = 0;
    for (int j = 0; j < NB; j++) rh[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // reference model: exact integer slicer input from own history
  task automatic model_step(input int x, output int exp);
    int s;
    for (int i = NF-1; i > 0; i--) xh[i] = xh[i-1];
    xh[0] = x;
    s = 0;
    for (int i = 0; i < NF; i++) s += ffc[i] * xh[i];
    for (int j = 0; j < NB; j++) s -= fbc[j] * rh[j];
    exp = (s >= 0) ? 1 : 0;
    for (int j = NB-1; j > 0; j--) rh[j] = rh[j-1];
    rh[0] = exp ? FS : -FS;
  endtask

  task automatic send(input int x, input bit junk, input string req);
    int exp;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sample = x[W-1:0];
    @(negedge clk);
    model_step(x, exp);
    chk(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
    chk(dec_valid == 1'b0, "R3 no strobe at accept", int'(dec_valid), 0);
    if (junk) begin in_valid = 1'b1; in_sample = 8'h64; end
    else      in_valid = 1'b0;
    repeat (W-1) @(negedge clk);
    chk(dec_valid == 1'b0 && in_ready == 1'b0, "R3 strobe not early",
        int'(dec_valid), 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(dec_valid == 1'b1, "R3 strobe after W edges", int'(dec_valid), 1);
    chk(in_ready == 1'b1, "R3 ready with strobe", int'(in_ready), 1);
    chk(int'(dec_symbol) == exp, req, int'(dec_symbol), exp);
    last_exp = exp;
    last_act = int'(dec_symbol);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lfsr, s0, s1, s2, x;
    do_reset();
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(dec_valid == 1'b0, "R1 no strobe after reset", int'(dec_valid), 0);
    // R1 and R6: zero history plus zero sample is a tie, resolving to +1
    send(0, 1'b0, "R1 R6 zero input tie");
    // strobe drops in the cycle after it was raised
    @(negedge clk);
    chk(dec_valid == 1'b0, "R3 strobe one cycle", int'(dec_valid), 0);

    // R5 R6 R7 R8: sweep every sample value, decisions feed back
    do_reset();
    for (int v = -(1 << (W-1)); v < (1 << (W-1)); v++)
      send(v, 1'b0, "R5 R6 R7 R8 sweep decision");
    for (int v = (1 << (W-1)) - 1; v >= -(1 << (W-1)); v -= 3)
      send(v, 1'b0, "R5 R7 descending sweep");

    // R4: samples offered during busy passes are dropped
    do_reset();
    send(-40, 1'b1, "R4 junk during busy");
    send(-10, 1'b1, "R4 junk during busy");
    send(5, 1'b0, "R4 later decision unaffected");
    send(-3, 1'b0, "R4 later decision unaffected");
    send(0, 1'b0, "R4 later decision unaffected");

    // R9: interfering channel, decisions must equal transmitted symbols
    do_reset();
    lfsr = 16'hACE1; s1 = 0; s2 = 0;
    for (int k = 0; k < 300; k++) begin
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      s0 = (lfsr & 1) ? 1 : -1;
      x  = 32*s0 + 24*s1 + 16*s2;
      send(x, 1'b0, "R9 model decision");
      chk(last_act == ((s0 > 0) ? 1 : 0), "R9 symbol recovered",
          last_act, (s0 > 0) ? 1 : 0);
      s2 = s1; s1 = s0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule